// File: doc/BRIEF.md
# I2C Banked EEPROM Target

This block is an I2C target that fronts a 1 KiB byte array. The array is held in registers and organised as four banks of 256 bytes. The controller selects a bank through two bits of the device byte and a location through a one-byte word address. The target supports four transfers:

- a single-byte write;
- a random read, which is a dummy write of the word address followed by a repeated START and a read;
- a current-address read;
- sequential reads, which continue for as long as the controller keeps acknowledging.

SCL and SDA are sampled by a faster system clock through two-flop synchronizers. The target drives SDA low through an open-drain enable and never drives it high.

One address pointer is kept, and the last transfer decides where a current-address read starts:

- After a read of address n, the pointer holds n+1.
- After a write, the pointer still holds the address that was just written.
- During a sequential read the pointer wraps from 255 back to 0 inside the selected bank.
- A read ends only when the controller sends a NACK after a byte and then a STOP.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0) and every byte of every bank reads as 0x00.
- R2: The device byte is laid out as [7:4] = 1010, [3:2] = bank, [1] = ignored, [0] = R/W (1 = read). With any other value in [7:4] the target gives no ACK, drives nothing and stores nothing until the next START.
- R3: A write transfer (device byte with R/W = 0, word address, one data byte) has all three bytes ACKed and stores the data at the word address in the selected bank.
- R4: A second data byte in the same write transfer is NACKed and is not stored.
- R5: A random read returns the byte at the word address, MSB first, in the bank chosen by the read device byte.
- R6: A current-address read issued after a write returns the byte at the address that was just written.
- R7: A current-address read issued after a read returns the byte one above the last address read.
- R8: While the controller ACKs after each byte, the target sends the following address next, and the address wraps from 255 to 0 within the bank.
- R9: A NACK after a read byte makes the target release SDA and stay silent until the next START.
- R10: The bank field selects independent storage: the same word address in different banks holds different bytes. Device-byte bit 1 has no effect.
- R11: The target changes `sda_oe_o` only while SCL is low. It releases SDA after a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line (raw) |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach is the pointer hand-off between transfers:

- the wrap from 255 to 0 in the middle of a sequential read;
- the difference between a current-address read that follows a write and one that follows a read.

The bench reaches these by writing bytes at 0xFE, 0xFF and 0x00. It then chains random, sequential and current-address reads, separated by STOPs, so that each read's expected byte depends on where the previous transfer left the pointer. A bad device ID and an extra data byte are sent as whole transfers, and the array is read back afterwards to show that nothing changed.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];

  p_bus_event_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({start_o, stop_o, scl_rise_o, scl_fall_o}) <= 1);
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int         BANK_W = 2,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int WORD_W = 8;
  localparam int MEM_AW = WORD_W + BANK_W;
  localparam logic [WORD_W-1:0] PTR_ONE = 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  i2c_ee_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  ee_state_e          st, nxt;
  logic [3:0]         cnt;
  logic [7:0]         sh, tx;
  logic [WORD_W-1:0]  ptr;
  logic [BANK_W-1:0]  bank;
  logic               ack_q, wr_done;
  logic               byte_end;
  logic               mem_we;
  logic [7:0]         rd_data;

  assign byte_end = scl_fall && (cnt == 4'd8);
  assign mem_we   = (st == ST_WDATA) && byte_end && !wr_done && !start_w && !stop_w;

  i2c_ee_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i ({bank, ptr}),
    .wdata_i (sh),
    .raddr_i ({bank, ptr}),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      bank    <= '0;
      ack_q   <= 1'b0;
      wr_done <= 1'b0;
    end else if (start_w) begin
      st  <= ST_DEV;
      cnt <= '0;
    end else if (stop_w) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            st  <= ST_ACK;
            if (st == ST_DEV) begin
              if (sh[7:4] == DEV_ID) begin
                bank    <= sh[2 +: BANK_W];
                ack_q   <= 1'b1;
                wr_done <= 1'b0;
                nxt     <= sh[0] ? ST_RDATA : ST_WADDR;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              ptr   <= sh;
              ack_q <= 1'b1;
              nxt   <= ST_WDATA;
            end else begin
              // one byte per write; extras are refused
              ack_q   <= !wr_done;
              wr_done <= 1'b1;
              nxt     <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st  <= nxt;
            cnt <= '0;
            if (nxt == ST_RDATA) tx <= rd_data;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st  <= ST_RACK;
              ptr <= ptr + PTR_ONE;
            end else begin
              tx  <= {tx[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              st  <= ST_RDATA;
              tx  <= rd_data;
              cnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_ACK:   sda_oe_o = ack_q;
      ST_RDATA: sda_oe_o = ~tx[7];
      default:  sda_oe_o = 1'b0;
    endcase
  end

  p_drive_low_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  p_stop_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);

  p_start_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_oe_o);

  p_dev_ack_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(st == ST_ACK) && $past(st) == ST_DEV) |-> sh[7:4] == DEV_ID);

  p_nack_silence_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam int LIMIT = 150000;
  localparam int NV    = 6;
  // {bank, word address, data}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'hA5}, {2'd1, 8'h00, 8'h3C}, {2'd2, 8'h7F, 8'h81},
    {2'd3, 8'hFF, 8'h5A}, {2'd0, 8'hFE, 8'h11}, {2'd0, 8'hFF, 8'h22}};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, ctl_sda = 1'b1;
  logic sda_oe, sda_bus;
  int   checks = 0, errors = 0, oe_hi_changes = 0;

  assign sda_bus = ctl_sda & ~sda_oe;
  always #(CLK_P/2) clk = ~clk;

  i2c_eeprom_target dut (.clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe));

  logic oe_d = 1'b0;
  always @(posedge clk) begin
    if (rst_n && sda_oe != oe_d && scl) oe_hi_changes++;
    oe_d <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] b, input logic rd, input logic b1 = 1'b0);
    return {4'b1010, b, b1, rd};
  endfunction

  task automatic start();
    ctl_sda = 1'b1; hw(); scl = 1'b1; hw(); ctl_sda = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic stop();
    ctl_sda = 1'b0; hw(); scl = 1'b1; hw(); ctl_sda = 1'b1; hw();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      ctl_sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
    end
    ctl_sda = 1'b1; hw(); scl = 1'b1; hw(); ack = ~sda_bus; scl = 1'b0; hw();
  endtask

  task automatic recv(input logic ack_it, output logic [7:0] b);
    ctl_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1; hw(); b[i] = sda_bus; scl = 1'b0;
    end
    ctl_sda = ~ack_it; hw(); scl = 1'b1; hw(); scl = 1'b0; hw(); ctl_sda = 1'b1;
  endtask

  task automatic wr(input logic [1:0] bk, input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    start(); send(dev(bk, 1'b0), a0); send(a, a1); send(d, a2); stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rrd(input logic [1:0] bk, input logic [7:0] a, output logic [7:0] d);
    logic ak;
    start(); send(dev(bk, 1'b0), ak); send(a, ak);
    start(); send(dev(bk, 1'b1), ak); recv(1'b0, d); stop();
  endtask

  task automatic crd(input logic [1:0] bk, output logic [7:0] d);
    logic ak;
    start(); send(dev(bk, 1'b1), ak); recv(1'b0, d); stop();
  endtask

  initial begin : wdog
    repeat (LIMIT) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic ok, ak, a1, a2;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", int'(sda_oe), 0);
    rrd(2'd0, 8'h00, d); chk("R1 bank0 0x00", d, 8'h00);
    rrd(2'd3, 8'hFF, d); chk("R1 bank3 0xFF", d, 8'h00);

    // table: write, then random read back (R3, R5, R10)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], ok);
      chk("R3 write acked", int'(ok), 1);
    end
    for (int i = 0; i < NV; i++) begin
      rrd(VEC[i][17:16], VEC[i][15:8], d);
      chk("R5 R10 read back", d, VEC[i][7:0]);
    end

    // R6: current read after write
    wr(2'd1, 8'h40, 8'h99, ok);
    crd(2'd1, d); chk("R6 current after write", d, 8'h99);

    // R7: current read after read
    rrd(2'd0, 8'hFE, d); chk("R5 read 0xFE", d, 8'h11);
    crd(2'd0, d); chk("R7 current after read", d, 8'h22);

    // R8: sequential with wrap, then R9 NACK release
    start(); send(dev(2'd0, 1'b0), ak); send(8'hFE, ak);
    start(); send(dev(2'd0, 1'b1), ak);
    recv(1'b1, d); chk("R8 seq byte0", d, 8'h11);
    recv(1'b1, d); chk("R8 seq byte1", d, 8'h22);
    recv(1'b0, d); chk("R8 seq wrap to 0", d, 8'hA5);
    hw(); hw();
    chk("R9 released after NACK", int'(sda_oe), 0);
    scl = 1'b1; hw(); chk("R9 bus high after NACK", int'(sda_bus), 1); scl = 1'b0; hw();
    stop();
    crd(2'd0, d); chk("R7 current after wrapped read", d, 8'h00);

    // R2: wrong device ID ignored
    start(); send(8'hB0, ak); chk("R2 bad id no ack", int'(ak), 0);
    send(8'h00, a1); send(8'hEE, a2); stop();
    chk("R2 no ack on addr", int'(a1), 0);
    chk("R2 no ack on data", int'(a2), 0);
    rrd(2'd0, 8'h00, d); chk("R2 memory untouched", d, 8'hA5);

    // R4: second data byte refused
    start(); send(dev(2'd2, 1'b0), ak); send(8'h10, ak);
    send(8'h44, a1); send(8'h55, a2); stop();
    chk("R4 first data acked", int'(a1), 1);
    chk("R4 second data nacked", int'(a2), 0);
    rrd(2'd2, 8'h10, d); chk("R4 first stored", d, 8'h44);
    rrd(2'd2, 8'h11, d); chk("R4 second not stored", d, 8'h00);

    // R10: device-byte bit 1 ignored
    start(); send(dev(2'd2, 1'b0, 1'b1), ak); chk("R10 bit1 acked", int'(ak), 1);
    send(8'h7F, ak);
    start(); send(dev(2'd2, 1'b1, 1'b1), ak); recv(1'b0, d); stop();
    chk("R10 bit1 ignored", d, 8'h81);

    chk("R11 oe changes while SCL high", oe_hi_changes, 0);
    chk("R11 released at end", int'(sda_oe), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule